// File: doc/BRIEF.md
# Byte-Paced I2C Bus Master

This block is an I2C bus master that software runs one byte at a time. A small register file holds control bits (start, stop, acknowledge value, rate, pin pair, interrupt enable), a status byte and one data buffer. Software loads the slave address into the buffer and sets the start bit. The block then issues a START condition and shifts the byte out MSB first. It samples the slave's acknowledge, raises a byte-done flag and holds SCL low until software decides what comes next.

Software then has three choices. A write to the buffer transmits another byte. A read of the buffer receives a byte and answers it with the acknowledge value from the control register; in a read transfer the first read returns a dummy value. Setting the stop bit while the block waits ends the transfer with a STOP condition. SCL runs at one of four rates derived from the system clock. The two lines can be steered to either of two open-drain pin pairs, each pin modelled as a pull-low enable.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control and status registers read 0, irq is 0 and all four pull-low enables are 0.
- R2: Setting control bit 0 (START) while the block is idle produces a START condition (SDA falls while SCL is high), then sends the data buffer MSB first; SDA only changes while SCL is low.
- R3: After the ninth clock of every byte, status bit 0 (byte done) becomes 1 and SCL stays low until software acts.
- R4: Any read or write of the data buffer (offset 2) clears byte done; reading status does not; irq equals byte done AND control bit 6 (interrupt enable).
- R5: Writing the data buffer while the block waits after a byte transmits the written value as the next byte.
- R6: After a transmitted byte, status bit 1 holds the SDA level seen in the acknowledge slot (0 = ACK, 1 = NACK).
- R7: Reading the data buffer while the block waits and STOP is clear returns the buffer and starts reception of a byte. The received byte is readable at offset 2 once byte done is set. In that byte's acknowledge slot the master pulls SDA low when control bit 2 is 0 and releases it when bit 2 is 1.
- R8: Setting control bit 1 (STOP) while the block waits produces a STOP condition (SDA rises while SCL is high), after which status bit 2 (busy) and control bit 1 read 0.
- R9: Control bits 4:3 select the SCL rate, 00/01/10/11 = 50/100/200/400 kHz, so one SCL period lasts CLK_HZ / (50000 << rate) system clocks.
- R10: Control bit 5 selects pin pair 1 when 1 and pair 0 when 0; the pair not selected is never pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset: 0 control, 1 status, 2 data buffer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data buffer) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 1 | Byte-done interrupt, gated by the enable bit |
| scl0_oe | output | 1 | Pair 0 SCL pull-low enable |
| sda0_oe | output | 1 | Pair 0 SDA pull-low enable |
| sda0_in | input | 1 | Pair 0 SDA line level |
| scl1_oe | output | 1 | Pair 1 SCL pull-low enable |
| sda1_oe | output | 1 | Pair 1 SDA pull-low enable |
| sda1_in | input | 1 | Pair 1 SDA line level |

## Verification
A bus-level slave model decodes START, STOP and bit values from the line levels, so the tests can detect several kinds of fault. A master that samples the acknowledge in the wrong phase reports the wrong ACK/NACK in status. A master whose divider is off by a phase shows the wrong SCL period for its rate code. The read flow is tested with a dummy read, an ACKed byte, then a NACKed byte ended by STOP. A design that confuses the two acknowledge encodings, starts a receive when STOP is pending, or overwrites the buffer early would return the wrong byte or the wrong acknowledge level. Other tests check that a status read leaves the interrupt pending, that SCL stays low while software waits, and that the unselected pin pair stays quiet.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BIT, ST_HOLD, ST_STOP
  } eng_state_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;

  localparam int unsigned BASE_HZ = 50_000;

  // SCL frequency for a rate code: doubles per step from the base rate.
  function automatic int unsigned scl_hz(input logic [1:0] code);
    return BASE_HZ << code;
  endfunction

  // System clocks per quarter of an SCL period, never below one.
  function automatic int unsigned quarter_len(input int unsigned clk_hz, input logic [1:0] code);
    int unsigned q;
    q = clk_hz / (4 * scl_hz(code));
    if (q == 0) q = 1;
    return q;
  endfunction
endpackage

// File: rtl/i2c_bm_clkdiv.sv
module i2c_bm_clkdiv
  import i2c_bm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int unsigned QMAX = quarter_len(CLK_HZ, 2'd0);
  localparam int CW = $clog2(QMAX + 1);

  logic [CW-1:0] cnt;
  logic [31:0]   qlim;

  assign qlim = quarter_len(CLK_HZ, rate);
  assign tick = en && ((32'(cnt) + 32'd1) >= qlim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start_cmd,
  input  logic              cmd_tx,
  input  logic              cmd_rx,
  input  logic              stop_req,
  input  logic              ack_out,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              sda_in,
  output logic              scl_drive,
  output logic              sda_drive,
  output logic              run,
  output logic              idle,
  output logic              hold,
  output logic              byte_done,
  output logic              stop_done,
  output logic              rx_mode,
  output logic              rx_ack,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] LAST = BW'(DATA_W);

  eng_state_t        st;
  logic [1:0]        ph;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] sh;
  logic              rx_q, ackl, rx_ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= '0; bitn <= '0; sh <= '0;
      rx_q <= 1'b0; ackl <= 1'b1; rx_ack_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start_cmd) begin
          st <= ST_START; ph <= '0; sh <= tx_byte; rx_q <= 1'b0;
        end
        ST_START: if (tick) begin
          if (ph == 2'd2) begin st <= ST_BIT; ph <= '0; bitn <= '0; end
          else ph <= ph + 2'd1;
        end
        ST_BIT: if (tick) begin
          if (ph == 2'd1) begin
            if (bitn == LAST) begin
              if (!rx_q) rx_ack_q <= sda_in;
            end else if (rx_q) begin
              sh <= {sh[DATA_W-2:0], sda_in};
            end
          end
          if (ph == 2'd3) begin
            if (bitn == LAST) st <= ST_HOLD;
            else begin
              bitn <= bitn + 1'b1;
              if (!rx_q) sh <= {sh[DATA_W-2:0], 1'b0};
            end
          end
          ph <= ph + 2'd1;
        end
        ST_HOLD: begin
          if (stop_req) begin
            st <= ST_STOP; ph <= '0;
          end else if (cmd_tx) begin
            st <= ST_BIT; ph <= '0; bitn <= '0; sh <= tx_byte; rx_q <= 1'b0;
          end else if (cmd_rx) begin
            st <= ST_BIT; ph <= '0; bitn <= '0; rx_q <= 1'b1; ackl <= ack_out;
          end
        end
        ST_STOP: if (tick) begin
          if (ph == 2'd2) st <= ST_IDLE;
          else ph <= ph + 2'd1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_drive = 1'b0;
    sda_drive = 1'b0;
    case (st)
      ST_START: begin scl_drive = (ph == 2'd2); sda_drive = (ph != 2'd0); end
      ST_BIT: begin
        scl_drive = (ph == 2'd0) || (ph == 2'd3);
        sda_drive = (bitn == LAST) ? (rx_q & ~ackl) : (~rx_q & ~sh[DATA_W-1]);
      end
      ST_HOLD:  scl_drive = 1'b1;
      ST_STOP: begin scl_drive = (ph == 2'd0); sda_drive = (ph != 2'd2); end
      default: ;
    endcase
  end

  assign run       = (st == ST_START) || (st == ST_BIT) || (st == ST_STOP);
  assign idle      = (st == ST_IDLE);
  assign hold      = (st == ST_HOLD);
  assign byte_done = (st == ST_BIT) && tick && (ph == 2'd3) && (bitn == LAST);
  assign stop_done = (st == ST_STOP) && tick && (ph == 2'd2);
  assign rx_mode   = rx_q;
  assign rx_ack    = rx_ack_q;
  assign rx_byte   = sh;

  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && ph == 2'd2) |-> $stable(sda_drive)); // R2
  AST_BIT_INDEX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT) |-> (bitn <= LAST)); // R5
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
  import i2c_bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       eng_idle,
  input  logic       eng_hold,
  input  logic       byte_done,
  input  logic       stop_done,
  input  logic       rx_mode,
  input  logic       rx_ack,
  input  logic [7:0] rx_byte,
  output logic       start_cmd,
  output logic       cmd_tx,
  output logic       cmd_rx,
  output logic       stop_req,
  output logic       ack_out,
  output logic [7:0] tx_byte,
  output logic [1:0] rate,
  output logic       pair_sel,
  output logic       done_flag,
  output logic       irq
);
  logic       start_q, stop_q, ack_q, irqen_q, pair_q, flag_q, rxack_q;
  logic [1:0] rate_q;
  logic [7:0] dbuf;
  logic       ctrl_wr, data_wr, data_rd;

  assign ctrl_wr = reg_wr && (reg_addr == REG_CTRL);
  assign data_wr = reg_wr && (reg_addr == REG_DATA);
  assign data_rd = reg_rd && !reg_wr && (reg_addr == REG_DATA);

  assign start_cmd = start_q & eng_idle;
  assign cmd_tx    = data_wr & eng_hold;
  assign cmd_rx    = data_rd & eng_hold & ~stop_q;
  assign stop_req  = stop_q;
  assign ack_out   = ack_q;
  assign tx_byte   = data_wr ? reg_wdata : dbuf;
  assign rate      = rate_q;
  assign pair_sel  = pair_q;
  assign done_flag = flag_q;
  assign irq       = flag_q & irqen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0; stop_q <= 1'b0; ack_q <= 1'b0; irqen_q <= 1'b0;
      pair_q <= 1'b0; rate_q <= 2'd0; dbuf <= '0; flag_q <= 1'b0; rxack_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        start_q <= reg_wdata[0];
        stop_q  <= reg_wdata[1] & ~eng_idle;
        ack_q   <= reg_wdata[2];
        rate_q  <= reg_wdata[4:3];
        pair_q  <= reg_wdata[5];
        irqen_q <= reg_wdata[6];
      end
      if (start_cmd) start_q <= 1'b0;
      if (stop_done) stop_q <= 1'b0;
      if (data_wr)                    dbuf <= reg_wdata;
      else if (byte_done && rx_mode)  dbuf <= rx_byte;
      if (byte_done)                  flag_q <= 1'b1;
      else if (data_wr || data_rd)    flag_q <= 1'b0;
      if (byte_done && !rx_mode)      rxack_q <= rx_ack;
    end
  end

  always_comb begin
    case (reg_addr)
      REG_CTRL: reg_rdata = {1'b0, irqen_q, pair_q, rate_q, ack_q, stop_q, start_q};
      REG_STAT: reg_rdata = {5'b0, ~eng_idle, rxack_q, flag_q};
      REG_DATA: reg_rdata = dbuf;
      default:  reg_rdata = 8'h00;
    endcase
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> !eng_idle); // R2
  AST_ACCESS_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_wr || data_rd) && !byte_done) |=> !flag_q); // R4
  AST_STOP_BIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_done && !ctrl_wr) |=> !stop_q); // R8
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl0_oe,
  output logic       sda0_oe,
  input  logic       sda0_in,
  output logic       scl1_oe,
  output logic       sda1_oe,
  input  logic       sda1_in
);
  localparam int NPAIR = 2;

  logic       tick, start_cmd, cmd_tx, cmd_rx, stop_req, ack_out;
  logic       scl_drive, sda_drive, run, idle, hold, byte_done, stop_done;
  logic       rx_mode, rx_ack, pair_sel, done_flag, sda_sel_in, scl_active;
  logic [1:0] rate;
  logic [7:0] tx_byte, rx_byte;
  logic [NPAIR-1:0] scl_oe_v, sda_oe_v, sda_in_v;

  i2c_bm_regs u_regs (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
    .eng_idle(idle), .eng_hold(hold), .byte_done, .stop_done, .rx_mode,
    .rx_ack, .rx_byte, .start_cmd, .cmd_tx, .cmd_rx, .stop_req, .ack_out,
    .tx_byte, .rate, .pair_sel, .done_flag, .irq
  );

  i2c_bm_clkdiv #(.CLK_HZ(CLK_HZ)) u_div (
    .clk, .rst_n, .en(run), .rate, .tick
  );

  i2c_bm_engine #(.DATA_W(8)) u_eng (
    .clk, .rst_n, .tick, .start_cmd, .cmd_tx, .cmd_rx, .stop_req, .ack_out,
    .tx_byte, .sda_in(sda_sel_in), .scl_drive, .sda_drive, .run, .idle,
    .hold, .byte_done, .stop_done, .rx_mode, .rx_ack, .rx_byte
  );

  assign sda_in_v = {sda1_in, sda0_in};

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign scl_oe_v[p] = (pair_sel == 1'(p)) & scl_drive;
    assign sda_oe_v[p] = (pair_sel == 1'(p)) & sda_drive;
  end

  assign sda_sel_in = sda_in_v[pair_sel];
  assign scl_active = scl_oe_v[pair_sel];
  assign scl0_oe = scl_oe_v[0];
  assign sda0_oe = sda_oe_v[0];
  assign scl1_oe = scl_oe_v[1];
  assign sda1_oe = sda_oe_v[1];

  AST_DONE_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> scl_active); // R3
endmodule

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  localparam int unsigned CLK = 8_000_000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic irq, scl0_oe, sda0_oe, scl1_oe, sda1_oe, sda0_in, sda1_in;

  i2c_byte_master #(.CLK_HZ(CLK)) dut (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata, .irq,
    .scl0_oe, .sda0_oe, .sda0_in, .scl1_oe, .sda1_oe, .sda1_in
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Slave model on the selected pair
  logic slv_pair = 1'b0, slv_drv = 1'b0, slv_ack_low = 1'b1, slv_reading = 1'b0;
  logic [7:0] slv_data [4] = '{8'hC3, 8'h96, 8'hFF, 8'hFF};
  logic scl_l, sda_l, pscl = 1'b1, psda = 1'b1;
  logic [7:0] obs_byte = 8'h00;
  logic obs_ack = 1'b1;
  bit first_byte = 1;
  int bitcnt = 0, rd_idx = 0, starts = 0, stops = 0, last_pos = 0, per_meas = 0;
  int p0_touch = 0, p1_touch = 0;

  assign scl_l   = slv_pair ? ~scl1_oe : ~scl0_oe;
  assign sda_l   = ~((slv_pair ? sda1_oe : sda0_oe) | slv_drv);
  assign sda0_in = ~(sda0_oe | (~slv_pair & slv_drv));
  assign sda1_in = ~(sda1_oe | (slv_pair & slv_drv));

  always @(posedge clk) begin
    if (slv_pair && (scl0_oe || sda0_oe)) p0_touch++;
    if (!slv_pair && (scl1_oe || sda1_oe)) p1_touch++;
  end

  always @(scl_l or sda_l) begin
    if (scl_l === 1'b1 && pscl === 1'b1 && psda === 1'b1 && sda_l === 1'b0) begin
      starts++; bitcnt = 0; first_byte = 1; rd_idx = 0; slv_drv = 1'b0;
    end else if (scl_l === 1'b1 && pscl === 1'b1 && psda === 1'b0 && sda_l === 1'b1) begin
      stops++; bitcnt = 0; first_byte = 1; slv_drv = 1'b0;
    end else if (scl_l === 1'b1 && pscl === 1'b0) begin
      if (bitcnt < 8) obs_byte = {obs_byte[6:0], sda_l};
      else begin
        obs_ack = sda_l;
        if (!first_byte && slv_reading) rd_idx++;
        first_byte = 0;
      end
      if (bitcnt == 1) per_meas = cyc - last_pos;
      last_pos = cyc;
      bitcnt = (bitcnt == 8) ? 0 : bitcnt + 1;
    end else if (scl_l === 1'b0 && pscl === 1'b1) begin
      if (slv_reading && !first_byte)
        slv_drv = (bitcnt < 8) ? ~slv_data[rd_idx][7 - bitcnt] : 1'b0;
      else
        slv_drv = (bitcnt == 8) ? slv_ack_low : 1'b0;
    end
    pscl = scl_l; psda = sda_l;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      peek(2'd1, s);
      if (s[0]) return;
    end
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      peek(2'd1, s);
      if (!s[2]) return;
    end
  endtask

  function automatic logic [7:0] ctrl(input logic ie, input logic pr, input logic [1:0] r,
                                      input logic ak, input logic sp, input logic st);
    return {1'b0, ie, pr, r, ak, sp, st};
  endfunction

  // {rate, byte, nack}
  localparam logic [10:0] VEC [4] = '{
    {2'd0, 8'hA5, 1'b0}, {2'd1, 8'h3C, 1'b1}, {2'd2, 8'h81, 1'b0}, {2'd3, 8'h5A, 1'b1}
  };

  task automatic run_write(input logic [1:0] r, input logic [7:0] b, input logic nk, input logic pr);
    logic [7:0] s;
    int st0;
    slv_pair = pr; slv_ack_low = ~nk; slv_reading = 1'b0;
    st0 = stops;
    wr(2'd2, b);
    wr(2'd0, ctrl(1'b1, pr, r, 1'b0, 1'b0, 1'b1));
    wait_done();
    chk("R2 first byte on bus", {24'h0, obs_byte}, {24'h0, b});
    peek(2'd1, s);
    chk("R6 received ack in status", {31'h0, s[1]}, {31'h0, nk});
    chk("R9 SCL period", per_meas, CLK / (50000 * (1 << r)));
    chk("R4 irq with enable", {31'h0, irq}, 32'd1);
    wr(2'd2, ~b);
    peek(2'd1, s);
    chk("R4 data write clears done", {31'h0, s[0]}, 32'd0);
    wait_done();
    chk("R5 second byte on bus", {24'h0, obs_byte}, {24'h0, ~b});
    wr(2'd0, ctrl(1'b1, pr, r, 1'b0, 1'b1, 1'b0));
    wait_idle();
    chk("R8 stop condition seen", stops - st0, 32'd1);
    peek(2'd0, s);
    chk("R8 stop bit reads 0", {31'h0, s[1]}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] s;
    repeat (3) @(negedge clk);
    // R1 reset state
    peek(2'd0, s); chk("R1 control after reset", {24'h0, s}, 32'h0);
    peek(2'd1, s); chk("R1 status after reset", {24'h0, s}, 32'h0);
    chk("R1 irq and pins after reset", {27'h0, irq, scl0_oe, sda0_oe, scl1_oe, sda1_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    peek(2'd1, s); chk("R1 status after release", {24'h0, s}, 32'h0);

    for (int v = 0; v < 4; v++)
      run_write(VEC[v][10:9], VEC[v][8:1], VEC[v][0], 1'b0);
    chk("R10 pair 1 quiet while pair 0 used", p1_touch, 32'd0);

    // R10 pair 1
    run_write(2'd3, 8'h69, 1'b0, 1'b1);
    chk("R10 pair 0 quiet while pair 1 used", p0_touch, 32'd0);

    // R4 / R3 interrupt gating and SCL hold
    slv_pair = 1'b0; slv_ack_low = 1'b1; slv_reading = 1'b0;
    wr(2'd2, 8'h42);
    wr(2'd0, ctrl(1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1));
    wait_done();
    chk("R4 irq masked when disabled", {31'h0, irq}, 32'd0);
    repeat (300) @(negedge clk);
    chk("R3 SCL held low while waiting", {31'h0, scl_l}, 32'd0);
    peek(2'd1, s); chk("R3 done still set after wait", {31'h0, s[0]}, 32'd1);
    wr(2'd0, ctrl(1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0));
    chk("R4 irq after enabling", {31'h0, irq}, 32'd1);
    rd(2'd1, s); rd(2'd1, s);
    chk("R4 status read keeps done", {31'h0, s[0]}, 32'd1);
    wr(2'd0, ctrl(1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0));
    wait_idle();
    rd(2'd2, s);
    peek(2'd1, s);
    chk("R4 data read clears done", {31'h0, s[0]}, 32'd0);
    chk("R4 irq low after clear", {31'h0, irq}, 32'd0);

    // R7 read transfer: dummy read, ACKed byte, NACKed byte, stop
    slv_reading = 1'b1; slv_ack_low = 1'b1;
    wr(2'd2, 8'hA1);
    wr(2'd0, ctrl(1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1));
    wait_done();
    peek(2'd1, s); chk("R6 address acked", {31'h0, s[1]}, 32'd0);
    rd(2'd2, s);
    wait_done();
    chk("R7 master ACK drives SDA low", {31'h0, obs_ack}, 32'd0);
    wr(2'd0, ctrl(1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0));
    rd(2'd2, s);
    chk("R7 first received byte", {24'h0, s}, 32'hC3);
    wait_done();
    chk("R7 master NACK releases SDA", {31'h0, obs_ack}, 32'd1);
    wr(2'd0, ctrl(1'b1, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0));
    wait_idle();
    rd(2'd2, s);
    chk("R7 second received byte", {24'h0, s}, 32'h96);
    peek(2'd1, s);
    chk("R8 busy clear after stop", {31'h0, s[2]}, 32'd0);
    chk("R8 released bus after stop", {30'h0, scl_l, sda_l}, 32'd3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule